// File: doc/BRIEF.md
# Four-Bank Interleaved Block Reader

This block fetches one cache block of four words from four independent memory banks and returns it over a bus that is one word wide. Words are spread across the banks by their low address bits, so the four words of a block each sit in a different bank. One request starts all four banks together, so their access times overlap. The four words then leave on four consecutive cycles. A read costs about as much as a read from a memory four words wide, yet the return path stays one word wide.

Each bank is modelled as a storage array with a fixed access latency (`ACC_LAT`). Each bank also has a busy timer that covers its full cycle time (`BANK_CYC`). A bank is never restarted before that timer runs out.

A control state machine has four named states:
- `ST_IDLE`: the block can accept a request.
- `ST_SEND`: the one-cycle address transfer.
- `ST_HOLD`: a stall while any bank is still inside its cycle time.
- `ST_ACCESS`: the block waits out the access latency.

The transitions are:
- IDLE→SEND on an accepted request.
- SEND→ACCESS when every bank is free, or SEND→HOLD when a bank is busy.
- HOLD→ACCESS once all bank timers have expired.
- ACCESS→IDLE when the latency count reaches zero. On that edge the four bank words are handed to a separate output streamer.

Because the streamer is separate, a new request can be accepted while the previous block is still leaving. A load port writes single words into the arrays.

Top module: `ilv_block_reader`

## Requirements
- R1: After reset is released, `req_ready` is 1 and `rsp_valid` and `rsp_last` are 0. A reset asserted in the middle of a read abandons that read, and no words of it appear afterwards.
- R2: Word address w is held in bank w mod 4 at row w/4. A read of block b returns the contents of words 4b, 4b+1, 4b+2 and 4b+3.
- R3: The words of a block appear in ascending address order. `rsp_last` is 1 only together with the fourth word.
- R4: With the default parameters (`ACC_LAT`=`BANK_CYC`=10), a request accepted at clock edge E0 produces words that are visible after edges E11, E12, E13 and E14, which are consecutive cycles. No word is visible after E10, and `rsp_valid` is 0 after E15. The whole block read takes 15 cycles.
- R5: `req_ready` is 1 only in the idle state. It is 0 from the edge that accepts a request until the edge that hands the bank data to the streamer. A `req_valid` raised while `req_ready` is 0 is ignored and produces no response.
- R6: A bank is not restarted until `BANK_CYC` cycles after its previous start, and a request that finds a bank busy waits. With `ACC_LAT`=4 and `BANK_CYC`=10, a block accepted at E0 shows its first word after E5. A second request held valid is accepted at E6, and its first word appears after E15, not earlier.
- R7: When `wr_en` is 1 at an edge, `wr_data` is written into word `wr_addr`: bank `wr_addr[1:0]`, row `wr_addr[5:2]`. A later read returns the new value, and the other words are unchanged.
- R8: A new request may be accepted while the previous block is still streaming. With the default parameters and a second request held valid from E0, that request is accepted at E12, and its words appear after E23 to E26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block read request |
| req_blk | input | 4 | Block address (word address divided by 4) |
| req_ready | output | 1 | Request accepted on an edge where this and `req_valid` are both 1 |
| wr_en | input | 1 | Write one word into the bank arrays |
| wr_addr | input | 6 | Word address for the write |
| wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | A returned word is present |
| rsp_data | output | 32 | Returned word |
| rsp_last | output | 1 | Marks the fourth word of a block |

## Verification
Single block reads are run at the lowest block, the highest block and several middle blocks, with a distinct value stored in every word. This tells correct bank and row selection apart from swapped banks, reversed order or an off-by-one row. Each of those reads is checked cycle by cycle against the 15-cycle timing.

A read is also issued with a second request held valid. In a default instance this shows the streaming overlap. In an instance with a short access latency it shows the bank cycle-time stall, which separates the correct timer handling from a restart that comes too early. A single-cycle request while the block is busy, a rewritten word, and a reset in the middle of a read cover the ignore, load-port and abort cases.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_ACCESS = 2'd3
    } ilv_state_e;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DATA_W   = 32,
    parameter int ROW_W    = 4,
    parameter int BANK_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS  = 1 << ROW_W;
    localparam int TMR_W = $clog2(BANK_CYC + 1);

    logic [DATA_W-1:0] mem [ROWS];
    logic [TMR_W-1:0]  tmr_q;

    // storage array and read latch
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_row] <= wr_data;
        if (start)
            rdata <= mem[rd_row];
    end

    // cycle-time timer: nonzero while the bank may not be restarted
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_q <= '0;
        else if (start)
            tmr_q <= TMR_W'(BANK_CYC - 1);
        else if (tmr_q != '0)
            tmr_q <= tmr_q - 1'b1;
    end

    assign busy = (tmr_q != '0);

endmodule

// File: rtl/ilv_stream.sv
module ilv_stream #(
    parameter int NW     = 4,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NW-1:0][DATA_W-1:0]  words,
    output logic                       valid,
    output logic [DATA_W-1:0]          data,
    output logic                       last
);
    localparam int CNT_W = $clog2(NW + 1);

    logic [NW-1:0][DATA_W-1:0] buf_q;
    logic [CNT_W-1:0]          cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            buf_q <= words;
            cnt_q <= CNT_W'(NW);
        end else if (cnt_q != '0) begin
            for (int i = 0; i < NW - 1; i++)
                buf_q[i] <= buf_q[i+1];
            buf_q[NW-1] <= '0;
            cnt_q       <= cnt_q - 1'b1;
        end
    end

    assign valid = (cnt_q != '0);
    assign last  = (cnt_q == CNT_W'(1));
    assign data  = buf_q[0];

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int BLK_W   = 4,
    parameter int ACC_LAT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             banks_busy,
    output logic             req_ready,
    output logic             bank_start,
    output logic             stream_load,
    output logic [BLK_W-1:0] row
);
    localparam int ACC_W = $clog2(ACC_LAT + 1);

    ilv_state_e       st_q, st_d;
    logic [ACC_W-1:0] acc_q;
    logic [BLK_W-1:0] blk_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:          if (req_valid) st_d = ST_SEND;
            ST_SEND, ST_HOLD: st_d = banks_busy ? ST_HOLD : ST_ACCESS;
            ST_ACCESS:        if (acc_q == '0) st_d = ST_IDLE;
            default:          st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (st_q == ST_IDLE);
        bank_start  = ((st_q == ST_SEND) || (st_q == ST_HOLD)) && !banks_busy;
        stream_load = (st_q == ST_ACCESS) && (acc_q == '0);
        row         = blk_q;
    end

    // address latch and access-latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
            acc_q <= '0;
        end else begin
            if (req_ready && req_valid)
                blk_q <= req_blk;
            if (bank_start)
                acc_q <= ACC_W'(ACC_LAT - 1);
            else if ((st_q == ST_ACCESS) && (acc_q != '0))
                acc_q <= acc_q - 1'b1;
        end
    end

endmodule

// File: rtl/ilv_block_reader.sv
module ilv_block_reader #(
    parameter int DATA_W    = 32,
    parameter int BLK_W     = 4,
    parameter int BANK_BITS = 2,
    parameter int ACC_LAT   = 10,
    parameter int BANK_CYC  = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [BLK_W-1:0]            req_blk,
    output logic                        req_ready,
    input  logic                        wr_en,
    input  logic [BLK_W+BANK_BITS-1:0]  wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        rsp_last
);
    localparam int NBANK = 1 << BANK_BITS;

    logic [NBANK-1:0]             bank_busy;
    logic [NBANK-1:0][DATA_W-1:0] bank_q;
    logic                         bank_start;
    logic                         stream_load;
    logic [BLK_W-1:0]             rd_row;

    ilv_ctrl #(
        .BLK_W   (BLK_W),
        .ACC_LAT (ACC_LAT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_blk     (req_blk),
        .banks_busy  (|bank_busy),
        .req_ready   (req_ready),
        .bank_start  (bank_start),
        .stream_load (stream_load),
        .row         (rd_row)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        ilv_bank #(
            .DATA_W   (DATA_W),
            .ROW_W    (BLK_W),
            .BANK_CYC (BANK_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (bank_start),
            .rd_row  (rd_row),
            .wr_en   (wr_en && (wr_addr[BANK_BITS-1:0] == BANK_BITS'(g))),
            .wr_row  (wr_addr[BLK_W+BANK_BITS-1:BANK_BITS]),
            .wr_data (wr_data),
            .busy    (bank_busy[g]),
            .rdata   (bank_q[g])
        );
    end

    ilv_stream #(
        .NW     (NBANK),
        .DATA_W (DATA_W)
    ) u_stream (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stream_load),
        .words (bank_q),
        .valid (rsp_valid),
        .data  (rsp_data),
        .last  (rsp_last)
    );

endmodule

// File: rtl/ilv_block_reader_chk.sv
module ilv_block_reader_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_last,
    input logic [NBANK-1:0] bank_busy,
    input logic             bank_start,
    input logic             stream_load
);
    // R3
    last_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    // R4
    words_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> rsp_valid);

    // R5
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    start_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_start |-> (bank_busy == '0));

    // R6
    timers_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_start |=> (bank_busy == '1));

    // R8
    no_stream_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_load |-> !rsp_valid);

endmodule

bind ilv_block_reader ilv_block_reader_chk #(
    .NBANK (1 << BANK_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_last    (rsp_last),
    .bank_busy   (bank_busy),
    .bank_start  (bank_start),
    .stream_load (stream_load)
);

// File: tb/sim_ilv_block_reader.sv
`timescale 1ns/1ps
module sim_ilv_block_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv   [2];
    logic [3:0]  rb   [2];
    logic        rr   [2];
    logic        ov   [2];
    logic [31:0] od   [2];
    logic        ol   [2];
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;

    logic [31:0] model [64];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ilv_block_reader u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_blk(rb[0]), .req_ready(rr[0]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp_valid(ov[0]), .rsp_data(od[0]), .rsp_last(ol[0]));

    ilv_block_reader #(.ACC_LAT(4), .BANK_CYC(10)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_blk(rb[1]), .req_ready(rr[1]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp_valid(ov[1]), .rsp_data(od[1]), .rsp_last(ol[1]));

    function automatic logic [31:0] pat(input int w);
        return {8'hC3, 8'(w), ~8'(w), 8'(w * 7)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic write_word(input int w, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(w); wr_data = v;
        model[w] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // single read on u0; poke raises a stray request while busy (R5)
    task automatic run_single(input int blk, input bit poke, input string tag);
        @(negedge clk);
        chk(rr[0] == 1'b1, "R5 ready before request", 32'(rr[0]), 32'd1);
        rv[0] = 1'b1; rb[0] = 4'(blk);
        @(negedge clk);                       // after E0
        rv[0] = 1'b0;
        chk(rr[0] == 1'b0, "R5 ready low after accept", 32'(rr[0]), 32'd0);
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);                   // after Ek
            if (poke && k == 3) begin rv[0] = 1'b1; rb[0] = 4'(blk ^ 1); end
            if (poke && k == 4) rv[0] = 1'b0;
            if (k == 10)
                chk(ov[0] == 1'b0, "R4 no word before E11", 32'(ov[0]), 32'd0);
            if (k >= 11 && k <= 14) begin
                chk(ov[0] == 1'b1, "R4 word valid", 32'(ov[0]), 32'd1);
                chk(od[0] == model[4*blk + k - 11], tag, od[0], model[4*blk + k - 11]);
                chk(ol[0] == (k == 14), "R3 last flag", 32'(ol[0]), 32'(k == 14));
            end
            if (k == 15)
                chk(ov[0] == 1'b0, "R4 valid low after E15", 32'(ov[0]), 32'd0);
        end
        if (poke) begin
            bit extra = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (ov[0]) extra = 1'b1;
            end
            chk(!extra, "R5 stray request ignored", 32'(extra), 32'd0);
            chk(rr[0] == 1'b1, "R5 idle after stray request", 32'(rr[0]), 32'd1);
        end
    endtask

    // two requests, second held valid from E0
    task automatic run_pair(input int inst, input int a, input int b,
                            input int a_first, input int b_first, input int acc_b, input string tag);
        @(negedge clk);
        rv[inst] = 1'b1; rb[inst] = 4'(a);
        @(negedge clk);                       // after E0
        rb[inst] = 4'(b);
        for (int k = 1; k <= b_first + 4; k++) begin
            @(negedge clk);
            if (k == acc_b - 1)
                chk(rr[inst] == 1'b1, {tag, " ready before second accept"}, 32'(rr[inst]), 32'd1);
            if (k == acc_b) begin
                chk(rr[inst] == 1'b0, {tag, " second accepted"}, 32'(rr[inst]), 32'd0);
                rv[inst] = 1'b0;
            end
            if (k >= a_first && k < a_first + 4) begin
                chk(ov[inst] && od[inst] == model[4*a + k - a_first], {tag, " first block word"},
                    od[inst], model[4*a + k - a_first]);
                chk(ol[inst] == (k == a_first + 3), "R3 last flag", 32'(ol[inst]), 32'(k == a_first + 3));
            end
            if (k == b_first - 1)
                chk(ov[inst] == 1'b0, {tag, " second block not early"}, 32'(ov[inst]), 32'd0);
            if (k >= b_first && k < b_first + 4) begin
                chk(ov[inst] && od[inst] == model[4*b + k - b_first], {tag, " second block word"},
                    od[inst], model[4*b + k - b_first]);
                chk(ol[inst] == (k == b_first + 3), "R3 last flag", 32'(ol[inst]), 32'(k == b_first + 3));
            end
            if (k == b_first + 4)
                chk(ov[inst] == 1'b0, {tag, " stream ends"}, 32'(ov[inst]), 32'd0);
        end
    endtask

    // stimulus table: block address, stray-request flag
    localparam int NVEC = 6;
    localparam int VEC [NVEC][2] = '{'{0, 0}, '{5, 0}, '{15, 1}, '{3, 0}, '{10, 1}, '{7, 0}};

    initial begin
        rv[0] = 1'b0; rv[1] = 1'b0; rb[0] = '0; rb[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 2; i++) begin
            chk(rr[i] == 1'b1, "R1 ready after reset", 32'(rr[i]), 32'd1);
            chk(ov[i] == 1'b0 && ol[i] == 1'b0, "R1 no output after reset", 32'({ov[i], ol[i]}), 32'd0);
        end

        for (int w = 0; w < 64; w++) write_word(w, pat(w));

        // R2 / R3 / R4 / R5 over the table
        for (int v = 0; v < NVEC; v++)
            run_single(VEC[v][0], VEC[v][1] != 0, "R2 bank word data");

        // R7 rewrite one word and read back
        write_word(9, 32'hDEAD_0009);
        run_single(2, 1'b0, "R7 rewritten block word");
        run_single(3, 1'b0, "R7 neighbour block unchanged");

        // R8 overlap on the default instance
        run_pair(0, 4, 12, 11, 23, 12, "R8");
        repeat (4) @(negedge clk);

        // R6 cycle-time stall on the short-latency instance
        run_pair(1, 6, 1, 5, 15, 6, "R6");
        repeat (12) @(negedge clk);
        run_pair(1, 15, 0, 5, 15, 6, "R6");
        repeat (12) @(negedge clk);

        // R1 reset in the middle of a read
        @(negedge clk);
        rv[0] = 1'b1; rb[0] = 4'd8;
        @(negedge clk);
        rv[0] = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (ov[0]) seen = 1'b1;
            end
            chk(!seen, "R1 aborted read returns nothing", 32'(seen), 32'd0);
            chk(rr[0] == 1'b1, "R1 ready after mid-read reset", 32'(rr[0]), 32'd1);
        end

        finish_run();
    end

endmodule